// File: doc/BRIEF.md
# Fixed-Format Serial Port with Receive Handshake

This block is a full-duplex asynchronous serial port whose frame is fixed: one start bit, eight data bits sent least significant first, an even parity bit and one stop bit. It needs no programming of a format. The bit rate comes from a selected reference tick stream. A prescaler divides that stream by 36 to make a ×16 oversample tick, so each bit lasts 576 reference ticks. A select input switches the source from the normal reference to an alternate test tick.

Software writes a byte into a transmit holding register. The byte moves into the shifter as soon as the shifter is free, and the transmit-empty flag then returns high. Received bytes land in a receive register, which sets receive-full. Reading that register clears the flag. A parity-error flag is refreshed with each received byte and never causes an interrupt. Each of the two flag conditions has a mask bit in front of a single combined interrupt output. A handshake output follows receive-full and is forced high while a companion clock enable is low.

Top module: `uart8e1_core`

## Requirements
- R1: The transmitted frame is a low start bit, then data bits 0 to 7 in that order, then a parity bit equal to the XOR of the data bits, then a high stop bit. Each bit lasts PRE_DIV×OVS (576) selected ticks, and the line idles high.
- R2: When `use_alt` is 1, bit timing counts only `alt_tick` pulses and ignores `ref_tick`. When it is 0, the reverse holds.
- R3: Out of reset `tx_empty` is 1. A write on `tx_wr` clears it on the next cycle. It stays 0 while the shifter is still sending an earlier byte, and it returns to 1 once the shifter takes the byte. Two back-to-back writes produce two consecutive frames.
- R4: Out of reset `rx_full` is 0. A complete received frame loads `rx_data` and sets `rx_full`. A pulse on `rx_rd` clears `rx_full`.
- R5: `par_err` is 0 out of reset. It changes only when a received byte completes. It then becomes 1 if the ones in data plus parity are odd, and 0 otherwise.
- R6: `par_err` never affects `irq`.
- R7: `irq` = (`tx_empty` AND NOT `mask_tx`) OR (`rx_full` AND NOT `mask_rx`). The masks do not change how the flags set or clear.
- R8: `hs_out` equals `rx_full` while `comp_clk_en` is 1, and it is 1 while `comp_clk_en` is 0.
- R9: A low level on `rxd` starts a frame only if the line is still low 8 oversample ticks later. A shorter low pulse is discarded and leaves `rx_full` at 0. The data and parity bits are sampled at the middle of each bit, every 16 oversample ticks after that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Normal reference tick enable |
| alt_tick | input | 1 | Alternate test tick enable |
| use_alt | input | 1 | 1 selects alt_tick as the timing source |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | 8 | Byte to transmit |
| rx_rd | input | 1 | Read strobe for the receive register |
| rx_data | output | 8 | Last received byte |
| tx_empty | output | 1 | Transmit holding register empty |
| rx_full | output | 1 | Receive register holds an unread byte |
| par_err | output | 1 | Parity of the last received byte was odd |
| mask_tx | input | 1 | Masks tx_empty from irq |
| mask_rx | input | 1 | Masks rx_full from irq |
| irq | output | 1 | Combined interrupt |
| comp_clk_en | input | 1 | Companion clock enable; 0 forces hs_out high |
| hs_out | output | 1 | Receive handshake output |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |

## Verification
The bench sends two bytes back to back and checks that the second one waits in the holding register. A design that cleared or set the empty flag at the wrong time, or dropped the waiting byte, would show a wrong flag or a missing second frame. It repeats a transmit with the alternate tick running at half the rate and samples at the doubled bit period, so a design that still counted the normal tick would place the wrong bits at those sample points. On receive, it sends a low pulse shorter than half a bit and then a genuine frame. A receiver that did not reject the false start would report a byte, or would miss the frame that follows. A frame with flipped parity must raise the error flag with the interrupt fully masked, and the next good frame must clear the flag.

// File: rtl/uart8e1_pkg.sv
package uart8e1_pkg;

   typedef enum logic [1:0] {
      RX_IDLE,
      RX_START,
      RX_BITS
   } rx_state_e;

   // even parity: the bit that makes the ones count of data+parity even
   function automatic logic even_par(input logic [7:0] d);
      return ^d;
   endfunction

endpackage

// File: rtl/u8e1_tick.sv
module u8e1_tick #(
   parameter int PRE_DIV = 36,
   parameter bit HAS_ALT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_tick,
   input  logic alt_tick,
   input  logic use_alt,
   output logic ovs_tick
);
   localparam int CW = $clog2(PRE_DIV);
   localparam logic [CW-1:0] LAST = CW'(PRE_DIV - 1);

   logic          sel_tick;
   logic [CW-1:0] cnt;

   generate
      if (HAS_ALT) begin : g_alt
         assign sel_tick = use_alt ? alt_tick : ref_tick;
      end else begin : g_ref
         assign sel_tick = ref_tick;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (sel_tick) begin
         cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
   end

   assign ovs_tick = sel_tick && (cnt == LAST);

endmodule

// File: rtl/u8e1_tx.sv
module u8e1_tx
   import uart8e1_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ovs_tick,
   input  logic       wr,
   input  logic [7:0] wdata,
   output logic       empty,
   output logic       txd
);
   localparam int OW = $clog2(OVS);
   localparam logic [OW-1:0] OLAST = OW'(OVS - 1);
   localparam logic [3:0]    BLAST = 4'd10;

   logic [7:0]    hold;
   logic          hold_full;
   logic          busy;
   logic [10:0]   sh;
   logic [OW-1:0] oc;
   logic [3:0]    bc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold      <= '0;
         hold_full <= 1'b0;
         busy      <= 1'b0;
         sh        <= '1;
         oc        <= '0;
         bc        <= '0;
      end else begin
         if (!busy && hold_full) begin
            busy      <= 1'b1;
            sh        <= {1'b1, even_par(hold), hold, 1'b0};
            oc        <= '0;
            bc        <= '0;
            hold_full <= 1'b0;
         end else if (busy && ovs_tick) begin
            if (oc == OLAST) begin
               oc <= '0;
               sh <= {1'b1, sh[10:1]};
               if (bc == BLAST) busy <= 1'b0;
               else             bc   <= bc + 1'b1;
            end else begin
               oc <= oc + 1'b1;
            end
         end
         if (wr) begin
            hold      <= wdata;
            hold_full <= 1'b1;
         end
      end
   end

   assign empty = ~hold_full;
   assign txd   = busy ? sh[0] : 1'b1;

endmodule

// File: rtl/u8e1_rx.sv
module u8e1_rx
   import uart8e1_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ovs_tick,
   input  logic       rxd,
   input  logic       rd,
   output logic [7:0] data,
   output logic       full,
   output logic       perr
);
   localparam int OW = $clog2(OVS);
   localparam logic [OW-1:0] OLAST = OW'(OVS - 1);
   localparam logic [OW-1:0] OMID  = OW'(OVS / 2 - 1);
   localparam logic [3:0]    BSTOP = 4'd9;

   logic [1:0]    sy;
   logic          rxs;
   rx_state_e     st;
   logic [OW-1:0] oc;
   logic [3:0]    bc;
   logic [8:0]    sh;

   assign rxs = sy[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sy   <= 2'b11;
         st   <= RX_IDLE;
         oc   <= '0;
         bc   <= '0;
         sh   <= '0;
         data <= '0;
         full <= 1'b0;
         perr <= 1'b0;
      end else begin
         sy <= {sy[0], rxd};
         if (rd) full <= 1'b0;
         if (ovs_tick) begin
            unique case (st)
               RX_IDLE: begin
                  if (!rxs) begin
                     st <= RX_START;
                     oc <= '0;
                  end
               end
               RX_START: begin
                  if (oc == OMID) begin
                     oc <= '0;
                     bc <= '0;
                     st <= rxs ? RX_IDLE : RX_BITS;
                  end else begin
                     oc <= oc + 1'b1;
                  end
               end
               RX_BITS: begin
                  if (oc == OLAST) begin
                     oc <= '0;
                     if (bc == BSTOP) begin
                        data <= sh[7:0];
                        perr <= ^sh;
                        full <= 1'b1;
                        st   <= RX_IDLE;
                     end else begin
                        sh <= {rxs, sh[8:1]};
                        bc <= bc + 1'b1;
                     end
                  end else begin
                     oc <= oc + 1'b1;
                  end
               end
               default: st <= RX_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/uart8e1_core.sv
module uart8e1_core #(
   parameter int PRE_DIV = 36,
   parameter int OVS     = 16,
   parameter bit HAS_ALT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_tick,
   input  logic       alt_tick,
   input  logic       use_alt,
   input  logic       tx_wr,
   input  logic [7:0] tx_data,
   input  logic       rx_rd,
   output logic [7:0] rx_data,
   output logic       tx_empty,
   output logic       rx_full,
   output logic       par_err,
   input  logic       mask_tx,
   input  logic       mask_rx,
   output logic       irq,
   input  logic       comp_clk_en,
   output logic       hs_out,
   output logic       txd,
   input  logic       rxd
);
   generate
      if (PRE_DIV < 2) begin : g_bad_pre
         $error("PRE_DIV must be at least 2");
      end
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 4");
      end
   endgenerate

   logic ovs_tick;

   u8e1_tick #(.PRE_DIV(PRE_DIV), .HAS_ALT(HAS_ALT)) u_tick (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .alt_tick(alt_tick),
      .use_alt(use_alt), .ovs_tick(ovs_tick)
   );

   u8e1_tx #(.OVS(OVS)) u_tx (
      .clk(clk), .rst_n(rst_n), .ovs_tick(ovs_tick), .wr(tx_wr),
      .wdata(tx_data), .empty(tx_empty), .txd(txd)
   );

   u8e1_rx #(.OVS(OVS)) u_rx (
      .clk(clk), .rst_n(rst_n), .ovs_tick(ovs_tick), .rxd(rxd), .rd(rx_rd),
      .data(rx_data), .full(rx_full), .perr(par_err)
   );

   assign irq    = (tx_empty & ~mask_tx) | (rx_full & ~mask_rx);
   assign hs_out = rx_full | ~comp_clk_en;

endmodule

// File: rtl/uart8e1_chk.sv
module uart8e1_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_wr,
   input logic tx_empty,
   input logic rx_rd,
   input logic rx_full,
   input logic par_err,
   input logic mask_tx,
   input logic mask_rx,
   input logic irq,
   input logic comp_clk_en,
   input logic hs_out
);
   // R3
   wr_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_wr |=> !tx_empty);

   // R4
   full_drop_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_full) |-> $past(rx_rd));

   // R5
   perr_moves_with_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(par_err) |-> rx_full);

   // R7
   all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_tx && mask_rx) |-> !irq);

   // R8
   hs_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !comp_clk_en |-> hs_out);

   // R8
   hs_follows_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      comp_clk_en |-> (hs_out == rx_full));

endmodule

bind uart8e1_core uart8e1_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_empty(tx_empty),
   .rx_rd(rx_rd), .rx_full(rx_full), .par_err(par_err), .mask_tx(mask_tx),
   .mask_rx(mask_rx), .irq(irq), .comp_clk_en(comp_clk_en), .hs_out(hs_out)
);

// File: tb/uart8e1_core_bench.sv
`timescale 1ns/1ps
module uart8e1_core_bench;
   localparam int BL_REF = 576;
   localparam int BL_ALT = 1152;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_tick = 1'b1;
   logic       alt_tick = 1'b0;
   logic       use_alt = 1'b0;
   logic       tx_wr = 1'b0;
   logic [7:0] tx_data = '0;
   logic       rx_rd = 1'b0;
   logic [7:0] rx_data;
   logic       tx_empty, rx_full, par_err, irq, hs_out, txd;
   logic       mask_tx = 1'b0, mask_rx = 1'b0;
   logic       comp_clk_en = 1'b0;
   logic       rxd = 1'b1;

   int  total = 0;
   int  bad = 0;
   bit  mon_on = 1'b0;
   bit  finished = 1'b0;

   always #10 clk = ~clk;

   always @(negedge clk) alt_tick <= ~alt_tick;

   uart8e1_core u_uart8e1_core (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .alt_tick(alt_tick),
      .use_alt(use_alt), .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd),
      .rx_data(rx_data), .tx_empty(tx_empty), .rx_full(rx_full),
      .par_err(par_err), .mask_tx(mask_tx), .mask_rx(mask_rx), .irq(irq),
      .comp_clk_en(comp_clk_en), .hs_out(hs_out), .txd(txd), .rxd(rxd)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // every-clock model of the combined outputs (R7, R8)
   always @(negedge clk) begin
      if (mon_on && rst_n) begin
         chk("R7 irq", int'(irq),
             int'((tx_empty && !mask_tx) || (rx_full && !mask_rx)));
         chk("R8 hs_out", int'(hs_out), int'(rx_full || !comp_clk_en));
      end
   end

   task automatic do_wr(input logic [7:0] d);
      @(negedge clk);
      tx_data = d;
      tx_wr = 1'b1;
      @(negedge clk);
      tx_wr = 1'b0;
   endtask

   task automatic do_rd();
      @(negedge clk);
      rx_rd = 1'b1;
      @(negedge clk);
      rx_rd = 1'b0;
   endtask

   task automatic cap(input int bl, output logic [10:0] f);
      do @(negedge clk); while (txd !== 1'b0);
      repeat (bl / 2) @(negedge clk);
      f[0] = txd;
      for (int i = 1; i < 11; i++) begin
         repeat (bl) @(negedge clk);
         f[i] = txd;
      end
   endtask

   function automatic logic [10:0] frame_of(input logic [7:0] d);
      return {1'b1, ^d, d, 1'b0};
   endfunction

   task automatic send_rx(input int bl, input logic [7:0] d, input bit flip);
      logic [10:0] f;
      f = {1'b1, (^d) ^ flip, d, 1'b0};
      for (int i = 0; i < 11; i++) begin
         @(negedge clk);
         rxd = f[i];
         repeat (bl - 1) @(negedge clk);
      end
      repeat (bl) @(negedge clk);
   endtask

   initial begin
      logic [10:0] f1, f2;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk("R3 reset tx_empty", int'(tx_empty), 1);
      chk("R4 reset rx_full", int'(rx_full), 0);
      chk("R5 reset par_err", int'(par_err), 0);
      chk("R1 idle txd", int'(txd), 1);
      chk("R8 hs forced", int'(hs_out), 1);
      mon_on = 1'b1;
      comp_clk_en = 1'b1;
      @(negedge clk);
      chk("R8 hs follows", int'(hs_out), 0);

      // back-to-back transmit
      fork
         begin
            cap(BL_REF, f1);
            cap(BL_REF, f2);
         end
         begin
            do_wr(8'hA5);
            chk("R3 empty cleared", int'(tx_empty), 0);
            repeat (5) @(negedge clk);
            chk("R3 empty after load", int'(tx_empty), 1);
            do_wr(8'h4E);
            repeat (200) @(negedge clk);
            chk("R3 empty held while busy", int'(tx_empty), 0);
         end
      join
      chk("R1 frame A5", int'(f1), int'(frame_of(8'hA5)));
      chk("R3 second frame 4E", int'(f2), int'(frame_of(8'h4E)));
      repeat (BL_REF) @(negedge clk);
      chk("R3 empty after both", int'(tx_empty), 1);
      chk("R1 idle high", int'(txd), 1);

      // alternate tick source at half rate
      use_alt = 1'b1;
      fork
         cap(BL_ALT, f1);
         do_wr(8'h35);
      join
      chk("R2 alt frame 35", int'(f1), int'(frame_of(8'h35)));
      repeat (BL_ALT) @(negedge clk);
      use_alt = 1'b0;

      // good receive
      send_rx(BL_REF, 8'h3C, 1'b0);
      chk("R4 full set", int'(rx_full), 1);
      chk("R4 data 3C", int'(rx_data), 'h3C);
      chk("R5 no parity error", int'(par_err), 0);
      chk("R8 hs high on full", int'(hs_out), 1);

      // masks
      mask_tx = 1'b1; mask_rx = 1'b1;
      @(negedge clk);
      chk("R7 masked irq", int'(irq), 0);
      chk("R7 flag kept under mask", int'(rx_full), 1);
      mask_rx = 1'b0;
      @(negedge clk);
      chk("R7 rx unmasked irq", int'(irq), 1);

      // companion clock stopped, then read
      comp_clk_en = 1'b0;
      do_rd();
      chk("R4 read clears", int'(rx_full), 0);
      chk("R8 hs forced after read", int'(hs_out), 1);
      comp_clk_en = 1'b1;
      @(negedge clk);
      chk("R8 hs low again", int'(hs_out), 0);

      // bad parity with all masked
      mask_tx = 1'b1; mask_rx = 1'b1;
      send_rx(BL_REF, 8'hC3, 1'b1);
      chk("R5 parity error set", int'(par_err), 1);
      chk("R4 data C3", int'(rx_data), 'hC3);
      chk("R6 perr no irq", int'(irq), 0);
      do_rd();
      chk("R5 perr holds after read", int'(par_err), 1);
      mask_tx = 1'b0; mask_rx = 1'b0;
      send_rx(BL_REF, 8'h07, 1'b0);
      chk("R5 parity error cleared", int'(par_err), 0);
      chk("R4 data 07", int'(rx_data), 'h07);
      do_rd();

      // false start pulse
      @(negedge clk);
      rxd = 1'b0;
      repeat (200) @(negedge clk);
      rxd = 1'b1;
      repeat (12 * BL_REF) @(negedge clk);
      chk("R9 glitch rejected", int'(rx_full), 0);
      send_rx(BL_REF, 8'h81, 1'b0);
      chk("R9 frame after glitch", int'(rx_full), 1);
      chk("R9 data 81", int'(rx_data), 'h81);

      mon_on = 1'b0;
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (180000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule